// File: doc/BRIEF.md
# Serial Port Control and Status Unit

This block holds the programmable state of an asynchronous serial port and presents it to a CPU over a small register bus. It keeps the control register (enables, interrupt enables, clock source), the transfer-format and bit-rate registers, the transmit and receive data holding registers, and the status flags. The shifters and the baud divider sit outside. They talk to this unit through a load/acknowledge pair on the transmit side, a completion event with error bits on the receive side, and a bit-rate clock input.

The unit also decides what the port pins do. The transmit and receive pins carry serial traffic only while their enable bit is set; otherwise they fall back to general-purpose use. The serial clock pin either stays quiet, drives out the internal bit-rate clock, or serves as the external timing source, depending on the clock-select field. The CPU may change the clock source and the format only while both enables are off. Such a change made at any other time is dropped.

Top module: `sport_ctl`

## Requirements
- R1: After reset the control, format and transmit data registers read 0, the bit-rate register reads its reset parameter, and status reads 0x84 when the shifter reports idle (transmit-empty set, transmit-end set, all other flags 0).
- R2: Register addresses are: 0 format, 1 bit rate, 2 control, 3 transmit data, 4 status, 5 receive data. Control bits are [7] transmit irq enable, [6] receive irq enable, [5] transmit enable, [4] receive enable, [3] multiprocessor irq enable, [2] transmit-end irq enable, [1:0] clock select. Status bits are [7] transmit-empty, [6] receive-full, [5] overrun, [4] framing error, [3] parity error, [2] transmit-end (read-only), [1:0] zero.
- R3: A control write made while either enable is currently 1 keeps the old clock-select value, and a format write made then is dropped. The other control bits are still written.
- R4: Any control write with bit 5 at 0 sets transmit-empty to 1 and withdraws a pending load strobe.
- R5: A transmit data write raises the load strobe, presents the byte to the serializer and clears transmit-empty. An acknowledge drops the strobe and sets transmit-empty.
- R6: A receive-complete event, accepted only while receive enable is 1 and receive-full is 0, stores the byte, sets receive-full and records the parity and framing error bits that come with it.
- R7: A receive-complete event while receive-full is 1 sets overrun and leaves the receive data register and the error flags unchanged.
- R8: A status flag is cleared only by a status read that returns it as 1, followed by a status write with that bit at 0. Writing 1 has no effect, and a second write-0 without a new read has no effect.
- R9: Turning receive enable off leaves receive-full, the error flags and the receive data register unchanged.
- R10: The transmit pin follows the serializer output only while transmit enable is 1, otherwise the general-purpose value. The deserializer sees the receive pin only while receive enable is 1, otherwise idle high.
- R11: Clock select 01 drives the internal bit-rate clock onto the clock pin, with output enabled, from the first cycle the control write takes effect, regardless of the enables. Clock select 00 leaves the clock pin undriven.
- R12: Clock select 1x takes bit timing from the clock pin input, disables the baud divider, and ignores both the bit-rate register and the internal bit-rate clock.
- R13: The receive interrupt is receive irq enable AND receive-full. The error interrupt is receive irq enable AND any of overrun, framing or parity. The transmit interrupt is transmit irq enable AND transmit-empty. The transmit-end interrupt is its enable AND transmit-empty AND shifter idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_sel | input | 1 | Bus access select |
| cpu_wr | input | 1 | Write strobe |
| cpu_rd | input | 1 | Read strobe |
| cpu_addr | input | 3 | Register address |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data (combinational) |
| tx_data | output | DATA_W | Byte offered to the serializer |
| tx_load | output | 1 | Load strobe to the serializer |
| tx_ack | input | 1 | Serializer took the byte |
| tx_idle | input | 1 | Serializer shifter idle |
| rx_done | input | 1 | Deserializer finished a frame |
| rx_data | input | DATA_W | Received byte |
| rx_par_err | input | 1 | Parity error of this frame |
| rx_frm_err | input | 1 | Framing error of this frame |
| fmt | output | 8 | Transfer format to the shifters |
| mp_en | output | 1 | Multiprocessor irq enable to the deserializer |
| int_bitclk | input | 1 | Bit-rate clock from the baud divider |
| sck_in | input | 1 | Clock pin input |
| sck_out | output | 1 | Clock pin output value |
| sck_oe | output | 1 | Clock pin output enable |
| bit_clk | output | 1 | Selected bit timing clock for the shifters |
| div_rate | output | RATE_W | Bit-rate value to the baud divider |
| div_en | output | 1 | Baud divider enable |
| ser_txd | input | 1 | Serializer output bit |
| gp_txd | input | 1 | General-purpose value for the transmit pin |
| txd_pin | output | 1 | Transmit pin value |
| txd_serial | output | 1 | Transmit pin in serial function |
| rxd_pin | input | 1 | Receive pin value |
| ser_rxd | output | 1 | Receive bit to the deserializer |
| gp_rxd | output | 1 | Receive pin for general-purpose use |
| rxd_serial | output | 1 | Receive pin in serial function |
| irq_rxi | output | 1 | Receive-full interrupt |
| irq_eri | output | 1 | Receive error interrupt |
| irq_txi | output | 1 | Transmit-empty interrupt |
| irq_tei | output | 1 | Transmit-end interrupt |

## Verification
The bench builds the unit with its defaults: 8-bit data, an 8-bit bit-rate register reset to 0xFF, and the external-clock variant present. The full-width data path therefore carries the 0xA5 and 0x3C patterns, and the bit-rate reset value and its read-back are visible. The external-clock variant makes all three clock-select modes reachable, including the one that bypasses the divider. Rate and data widths below eight are covered only by the elaboration checks and the read-back zero extension.

// File: rtl/sport_pkg.sv
package sport_pkg;

   localparam int BUS_W = 8;

   typedef enum logic [2:0] {
      RA_FMT  = 3'd0,
      RA_RATE = 3'd1,
      RA_CTRL = 3'd2,
      RA_TXD  = 3'd3,
      RA_STAT = 3'd4,
      RA_RXD  = 3'd5
   } sport_addr_e;

   typedef struct packed {
      logic       tie;
      logic       rie;
      logic       txe;
      logic       rxe;
      logic       mpie;
      logic       teie;
      logic [1:0] cks;
   } sport_ctrl_t;

   // bit position of the transmit enable inside a control write
   localparam int CB_TXE = 5;

   // clearable flag indices; status bit = index + FLAG_LSB
   localparam int NFLAG    = 5;
   localparam int FLAG_LSB = 3;
   localparam int F_PER    = 0;
   localparam int F_FER    = 1;
   localparam int F_ORE    = 2;
   localparam int F_RDRF   = 3;
   localparam int F_TDRE   = 4;

   localparam logic [1:0] CKS_INT     = 2'b00;
   localparam logic [1:0] CKS_INT_OUT = 2'b01;

endpackage

// File: rtl/sport_cfg_regs.sv
module sport_cfg_regs
   import sport_pkg::*;
#(
   parameter int          RATE_W   = 8,
   parameter logic [RATE_W-1:0] RATE_RST = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_fmt,
   input  logic              wr_rate,
   input  logic              wr_ctrl,
   input  logic [BUS_W-1:0]  wdata,
   output sport_ctrl_t       ctrl,
   output logic [BUS_W-1:0]  fmt,
   output logic [RATE_W-1:0] rate,
   output logic              te_clr
);

   sport_ctrl_t       ctrl_q;
   logic [BUS_W-1:0]  fmt_q;
   logic [RATE_W-1:0] rate_q;
   logic              locked;
   logic [1:0]        cks_n;

   assign locked = ctrl_q.txe | ctrl_q.rxe;
   assign cks_n  = locked ? ctrl_q.cks : wdata[1:0];
   assign te_clr = wr_ctrl & ~wdata[CB_TXE];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         fmt_q  <= '0;
         rate_q <= RATE_RST;
      end else begin
         if (wr_ctrl) ctrl_q <= sport_ctrl_t'({wdata[BUS_W-1:2], cks_n});
         if (wr_fmt && !locked) fmt_q <= wdata;
         if (wr_rate) rate_q <= wdata[RATE_W-1:0];
      end
   end

   assign ctrl = ctrl_q;
   assign fmt  = fmt_q;
   assign rate = rate_q;

   // R3
   cks_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && (ctrl_q.txe || ctrl_q.rxe)) |=> $stable(ctrl_q.cks));

   // R3
   fmt_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q.txe || ctrl_q.rxe) |=> $stable(fmt_q));

endmodule

// File: rtl/sport_flags.sv
module sport_flags
   import sport_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              te_clr,
   input  logic              wr_tdr,
   input  logic              rd_stat,
   input  logic              wr_stat,
   input  logic [BUS_W-1:0]  wdata,
   input  logic              tx_ack,
   input  logic              tx_idle,
   input  logic              rx_en,
   input  logic              rx_done,
   input  logic [DATA_W-1:0] rx_data,
   input  logic              rx_par_err,
   input  logic              rx_frm_err,
   output logic [DATA_W-1:0] tdr,
   output logic              tx_load,
   output logic [DATA_W-1:0] rdr,
   output logic [BUS_W-1:0]  stat
);

   logic [NFLAG-1:0]  flg_q;
   logic [NFLAG-1:0]  set_v;
   logic [NFLAG-1:0]  kill_v;
   logic [NFLAG-1:0]  clr_v;
   logic [DATA_W-1:0] tdr_q;
   logic [DATA_W-1:0] rdr_q;
   logic              load_q;
   logic              rx_acc;
   logic              ovr;
   logic              take;
   logic              tend;

   assign rx_acc = rx_done & rx_en;
   assign ovr    = rx_acc & flg_q[F_RDRF];
   assign take   = rx_acc & ~flg_q[F_RDRF];

   always_comb begin
      set_v          = '0;
      kill_v         = '0;
      set_v[F_TDRE]  = te_clr | (tx_ack & ~wr_tdr);
      kill_v[F_TDRE] = wr_tdr;
      set_v[F_RDRF]  = take;
      set_v[F_ORE]   = ovr;
      set_v[F_FER]   = take & rx_frm_err;
      set_v[F_PER]   = take & rx_par_err;
   end

   assign clr_v = {NFLAG{wr_stat}} & ~wdata[FLAG_LSB +: NFLAG];

   // one flag cell per status bit: armed by a read that sees it set
   for (genvar i = 0; i < NFLAG; i++) begin : g_flag
      logic f_q;
      logic a_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            f_q <= 1'(i == F_TDRE);
            a_q <= 1'b0;
         end else begin
            f_q <= set_v[i] | (f_q & ~(clr_v[i] & a_q) & ~kill_v[i]);
            if (wr_stat)      a_q <= 1'b0;
            else if (rd_stat) a_q <= f_q;
         end
      end
      assign flg_q[i] = f_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tdr_q  <= '0;
         rdr_q  <= '0;
         load_q <= 1'b0;
      end else begin
         if (wr_tdr) tdr_q <= wdata[DATA_W-1:0];
         if (take)   rdr_q <= rx_data;
         if (te_clr)      load_q <= 1'b0;
         else if (wr_tdr) load_q <= 1'b1;
         else if (tx_ack) load_q <= 1'b0;
      end
   end

   assign tend    = flg_q[F_TDRE] & tx_idle;
   assign stat    = {flg_q, tend, 2'b00};
   assign tdr     = tdr_q;
   assign rdr     = rdr_q;
   assign tx_load = load_q;

   // R4
   tdre_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
      te_clr |=> (flg_q[F_TDRE] && !load_q));

   // R5
   ack_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_ack && !wr_tdr) |=> (flg_q[F_TDRE] && !load_q));

   // R7
   overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_acc && flg_q[F_RDRF]) |=> (flg_q[F_ORE] && $stable(rdr_q)));

   // R8
   wr_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stat && (&wdata[FLAG_LSB +: NFLAG])) |=> ((~flg_q & $past(flg_q)) == '0));

endmodule

// File: rtl/sport_pinmux.sv
module sport_pinmux
   import sport_pkg::*;
#(
   parameter bit EXT_CLK_EN = 1'b1,
   parameter bit RX_IDLE    = 1'b1
) (
   input  logic [1:0] cks,
   input  logic       txe,
   input  logic       rxe,
   input  logic       int_bitclk,
   input  logic       sck_in,
   input  logic       ser_txd,
   input  logic       gp_txd,
   input  logic       rxd_pin,
   output logic       sck_out,
   output logic       sck_oe,
   output logic       bit_clk,
   output logic       div_en,
   output logic       txd_pin,
   output logic       txd_serial,
   output logic       ser_rxd,
   output logic       gp_rxd,
   output logic       rxd_serial
);

   logic use_ext;

   if (EXT_CLK_EN) begin : g_ext
      assign use_ext = cks[1];
      assign bit_clk = use_ext ? sck_in : int_bitclk;
   end else begin : g_noext
      logic unused_ok;
      assign unused_ok = &{1'b0, sck_in};
      assign use_ext   = 1'b0;
      assign bit_clk   = int_bitclk;
   end

   assign sck_oe     = (cks == CKS_INT_OUT);
   assign sck_out    = sck_oe & int_bitclk;
   assign div_en     = ~use_ext;

   assign txd_serial = txe;
   assign txd_pin    = txe ? ser_txd : gp_txd;
   assign rxd_serial = rxe;
   assign ser_rxd    = rxe ? rxd_pin : RX_IDLE;
   assign gp_rxd     = rxd_pin;

endmodule

// File: rtl/sport_ctl.sv
module sport_ctl
   import sport_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int RATE_W     = 8,
   parameter logic [RATE_W-1:0] RATE_RST = '1,
   parameter bit EXT_CLK_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_sel,
   input  logic              cpu_wr,
   input  logic              cpu_rd,
   input  logic [2:0]        cpu_addr,
   input  logic [7:0]        cpu_wdata,
   output logic [7:0]        cpu_rdata,
   output logic [DATA_W-1:0] tx_data,
   output logic              tx_load,
   input  logic              tx_ack,
   input  logic              tx_idle,
   input  logic              rx_done,
   input  logic [DATA_W-1:0] rx_data,
   input  logic              rx_par_err,
   input  logic              rx_frm_err,
   output logic [7:0]        fmt,
   output logic              mp_en,
   input  logic              int_bitclk,
   input  logic              sck_in,
   output logic              sck_out,
   output logic              sck_oe,
   output logic              bit_clk,
   output logic [RATE_W-1:0] div_rate,
   output logic              div_en,
   input  logic              ser_txd,
   input  logic              gp_txd,
   output logic              txd_pin,
   output logic              txd_serial,
   input  logic              rxd_pin,
   output logic              ser_rxd,
   output logic              gp_rxd,
   output logic              rxd_serial,
   output logic              irq_rxi,
   output logic              irq_eri,
   output logic              irq_txi,
   output logic              irq_tei
);

   if (DATA_W < 5 || DATA_W > BUS_W) begin : g_bad_data
      $error("sport_ctl: DATA_W must lie in 5..8");
   end
   if (RATE_W < 1 || RATE_W > BUS_W) begin : g_bad_rate
      $error("sport_ctl: RATE_W must lie in 1..8");
   end

   sport_ctrl_t       ctrl;
   logic [RATE_W-1:0] rate;
   logic [DATA_W-1:0] tdr;
   logic [DATA_W-1:0] rdr;
   logic [BUS_W-1:0]  stat;
   logic              te_clr;
   logic              wr_en;
   logic              rd_en;
   logic              wr_fmt, wr_rate, wr_ctrl, wr_tdr, wr_stat, rd_stat;

   assign wr_en   = cpu_sel & cpu_wr;
   assign rd_en   = cpu_sel & cpu_rd;
   assign wr_fmt  = wr_en & (cpu_addr == RA_FMT);
   assign wr_rate = wr_en & (cpu_addr == RA_RATE);
   assign wr_ctrl = wr_en & (cpu_addr == RA_CTRL);
   assign wr_tdr  = wr_en & (cpu_addr == RA_TXD);
   assign wr_stat = wr_en & (cpu_addr == RA_STAT);
   assign rd_stat = rd_en & (cpu_addr == RA_STAT);

   sport_cfg_regs #(
      .RATE_W   (RATE_W),
      .RATE_RST (RATE_RST)
   ) u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_fmt  (wr_fmt),
      .wr_rate (wr_rate),
      .wr_ctrl (wr_ctrl),
      .wdata   (cpu_wdata),
      .ctrl    (ctrl),
      .fmt     (fmt),
      .rate    (rate),
      .te_clr  (te_clr)
   );

   sport_flags #(
      .DATA_W (DATA_W)
   ) u_flags (
      .clk        (clk),
      .rst_n      (rst_n),
      .te_clr     (te_clr),
      .wr_tdr     (wr_tdr),
      .rd_stat    (rd_stat),
      .wr_stat    (wr_stat),
      .wdata      (cpu_wdata),
      .tx_ack     (tx_ack),
      .tx_idle    (tx_idle),
      .rx_en      (ctrl.rxe),
      .rx_done    (rx_done),
      .rx_data    (rx_data),
      .rx_par_err (rx_par_err),
      .rx_frm_err (rx_frm_err),
      .tdr        (tdr),
      .tx_load    (tx_load),
      .rdr        (rdr),
      .stat       (stat)
   );

   sport_pinmux #(
      .EXT_CLK_EN (EXT_CLK_EN)
   ) u_pins (
      .cks        (ctrl.cks),
      .txe        (ctrl.txe),
      .rxe        (ctrl.rxe),
      .int_bitclk (int_bitclk),
      .sck_in     (sck_in),
      .ser_txd    (ser_txd),
      .gp_txd     (gp_txd),
      .rxd_pin    (rxd_pin),
      .sck_out    (sck_out),
      .sck_oe     (sck_oe),
      .bit_clk    (bit_clk),
      .div_en     (div_en),
      .txd_pin    (txd_pin),
      .txd_serial (txd_serial),
      .ser_rxd    (ser_rxd),
      .gp_rxd     (gp_rxd),
      .rxd_serial (rxd_serial)
   );

   always_comb begin
      unique case (cpu_addr)
         RA_FMT:  cpu_rdata = fmt;
         RA_RATE: cpu_rdata = BUS_W'(rate);
         RA_CTRL: cpu_rdata = ctrl;
         RA_TXD:  cpu_rdata = BUS_W'(tdr);
         RA_STAT: cpu_rdata = stat;
         RA_RXD:  cpu_rdata = BUS_W'(rdr);
         default: cpu_rdata = '0;
      endcase
   end

   assign tx_data  = tdr;
   assign div_rate = rate;
   assign mp_en    = ctrl.mpie;

   assign irq_rxi = ctrl.rie  & stat[FLAG_LSB + F_RDRF];
   assign irq_eri = ctrl.rie  & (stat[FLAG_LSB + F_ORE] | stat[FLAG_LSB + F_FER]
                                 | stat[FLAG_LSB + F_PER]);
   assign irq_txi = ctrl.tie  & stat[FLAG_LSB + F_TDRE];
   assign irq_tei = ctrl.teie & stat[FLAG_LSB + F_TDRE] & tx_idle;

   // R10
   txd_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && !cpu_wdata[CB_TXE]) |=> !txd_serial);

endmodule

// File: tb/sport_ctl_bench.sv
module sport_ctl_bench;

   localparam time HALF = 2ns;

   typedef struct {
      logic [7:0] exp;
      string      tag;
   } sb_item_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cpu_sel = 0, cpu_wr = 0, cpu_rd = 0;
   logic [2:0] cpu_addr = '0;
   logic [7:0] cpu_wdata = '0;
   logic [7:0] cpu_rdata;
   logic [7:0] tx_data;
   logic       tx_load;
   logic       tx_ack = 0, tx_idle = 1;
   logic       rx_done = 0;
   logic [7:0] rx_data = '0;
   logic       rx_par_err = 0, rx_frm_err = 0;
   logic [7:0] fmt;
   logic       mp_en;
   logic       int_bitclk = 0, sck_in = 0;
   logic       sck_out, sck_oe, bit_clk, div_en;
   logic [7:0] div_rate;
   logic       ser_txd = 0, gp_txd = 1;
   logic       txd_pin, txd_serial;
   logic       rxd_pin = 1;
   logic       ser_rxd, gp_rxd, rxd_serial;
   logic       irq_rxi, irq_eri, irq_txi, irq_tei;

   int checks = 0;
   int errors = 0;
   sb_item_t sb[$];

   always #(HALF) clk = ~clk;

   sport_ctl u_sport_ctl (
      .clk(clk), .rst_n(rst_n),
      .cpu_sel(cpu_sel), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
      .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
      .tx_data(tx_data), .tx_load(tx_load), .tx_ack(tx_ack), .tx_idle(tx_idle),
      .rx_done(rx_done), .rx_data(rx_data), .rx_par_err(rx_par_err),
      .rx_frm_err(rx_frm_err), .fmt(fmt), .mp_en(mp_en),
      .int_bitclk(int_bitclk), .sck_in(sck_in), .sck_out(sck_out), .sck_oe(sck_oe),
      .bit_clk(bit_clk), .div_rate(div_rate), .div_en(div_en),
      .ser_txd(ser_txd), .gp_txd(gp_txd), .txd_pin(txd_pin), .txd_serial(txd_serial),
      .rxd_pin(rxd_pin), .ser_rxd(ser_rxd), .gp_rxd(gp_rxd), .rxd_serial(rxd_serial),
      .irq_rxi(irq_rxi), .irq_eri(irq_eri), .irq_txi(irq_txi), .irq_tei(irq_tei)
   );

   // monitor: pops expected read data as reads appear on the bus
   always @(negedge clk) begin
      #1;
      if (cpu_sel && cpu_rd) begin
         checks++;
         if (sb.size() == 0) begin
            errors++;
            $display("FAIL scoreboard: read with no expectation, got %h", cpu_rdata);
         end else begin
            sb_item_t it;
            it = sb.pop_front();
            if (cpu_rdata !== it.exp) begin
               errors++;
               $display("FAIL %s: got %h expected %h", it.tag, cpu_rdata, it.exp);
            end
         end
      end
   end

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      cpu_sel = 1; cpu_wr = 1; cpu_addr = a; cpu_wdata = d;
      @(negedge clk);
      cpu_sel = 0; cpu_wr = 0;
   endtask

   task automatic rd(input logic [2:0] a, input logic [7:0] e, input string tag);
      sb_item_t it;
      @(negedge clk);
      cpu_sel = 1; cpu_rd = 1; cpu_addr = a;
      it.exp = e; it.tag = tag;
      sb.push_back(it);
      @(negedge clk);
      cpu_sel = 0; cpu_rd = 0;
   endtask

   task automatic chk(input logic [7:0] act, input logic [7:0] e, input string tag);
      checks++;
      if (act !== e) begin
         errors++;
         $display("FAIL %s: got %h expected %h", tag, act, e);
      end
   endtask

   task automatic pulse_ack();
      @(negedge clk); tx_ack = 1;
      @(negedge clk); tx_ack = 0;
   endtask

   task automatic pulse_rx(input logic [7:0] d, input logic pe, input logic fe);
      @(negedge clk); rx_done = 1; rx_data = d; rx_par_err = pe; rx_frm_err = fe;
      @(negedge clk); rx_done = 0; rx_par_err = 0; rx_frm_err = 0;
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      #(HALF * 2 * 200000);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;

      // R1 reset state
      rd(3'd2, 8'h00, "R1 ctrl");
      rd(3'd4, 8'h84, "R1 stat");
      rd(3'd1, 8'hFF, "R1 rate");
      rd(3'd0, 8'h00, "R1 fmt");

      // R2 read-back of format and rate
      wr(3'd1, 8'h1A);
      wr(3'd0, 8'h05);
      rd(3'd1, 8'h1A, "R2 rate");
      rd(3'd0, 8'h05, "R2 fmt");

      // R11 clock output appears with no enables set
      int_bitclk = 1;
      wr(3'd2, 8'h01);
      #1;
      chk({7'd0, sck_oe}, 8'h01, "R11 sck_oe");
      chk({7'd0, sck_out}, 8'h01, "R11 sck_out");
      chk({7'd0, txd_pin}, 8'h01, "R10 txd gpio");
      chk({7'd0, ser_rxd}, 8'h01, "R10 rxd idle");

      // R10 enables route the pins
      wr(3'd2, 8'h31);
      rxd_pin = 0;
      #1;
      chk({7'd0, txd_serial}, 8'h01, "R10 txd_serial");
      chk({7'd0, txd_pin}, 8'h00, "R10 txd from serializer");
      chk({7'd0, ser_rxd}, 8'h00, "R10 rxd to deserializer");

      // R3 lock while enabled
      wr(3'd2, 8'h32);
      rd(3'd2, 8'h31, "R3 cks held");
      wr(3'd0, 8'h77);
      rd(3'd0, 8'h05, "R3 fmt held");

      // R5 transmit load and acknowledge
      wr(3'd3, 8'h3C);
      #1;
      chk({7'd0, tx_load}, 8'h01, "R5 load");
      chk(tx_data, 8'h3C, "R5 data");
      rd(3'd4, 8'h00, "R5 tdre clear");
      pulse_ack();
      #1;
      chk({7'd0, tx_load}, 8'h00, "R5 load drop");
      rd(3'd4, 8'h84, "R5 tdre set");

      // R4 transmit disable forces empty
      wr(3'd3, 8'h55);
      wr(3'd2, 8'h11);
      #1;
      chk({7'd0, tx_load}, 8'h00, "R4 load withdrawn");
      rd(3'd4, 8'h84, "R4 tdre forced");

      // R6 receive then R7 overrun
      pulse_rx(8'hA5, 1, 0);
      rd(3'd5, 8'hA5, "R6 rx data");
      rd(3'd4, 8'hCC, "R6 flags");
      pulse_rx(8'h11, 0, 1);
      rd(3'd5, 8'hA5, "R7 rx data kept");
      rd(3'd4, 8'hEC, "R7 overrun");

      // R8 clearing rules
      wr(3'd4, 8'hFF);
      rd(3'd4, 8'hEC, "R8 write one");
      wr(3'd4, 8'hBF);
      rd(3'd4, 8'hAC, "R8 read then write zero");
      wr(3'd4, 8'hFF);
      wr(3'd4, 8'hDF);
      rd(3'd4, 8'hAC, "R8 write zero without read");

      // R9 receive disable keeps flags and data
      wr(3'd2, 8'h01);
      rd(3'd4, 8'hAC, "R9 flags kept");
      rd(3'd5, 8'hA5, "R9 data kept");
      // R6 event ignored while receive disabled
      pulse_rx(8'h77, 0, 0);
      rd(3'd5, 8'hA5, "R6 disabled rx");

      // R13 interrupts
      wr(3'd2, 8'hC5);
      #1;
      chk({irq_rxi, irq_eri, irq_txi, irq_tei}, 8'h07, "R13 irq set");
      tx_idle = 0;
      #1;
      chk({7'd0, irq_tei}, 8'h00, "R13 tei idle");

      // R12 external clock
      wr(3'd2, 8'h02);
      sck_in = 1; int_bitclk = 0;
      #1;
      chk({6'd0, sck_oe, div_en}, 8'h00, "R12 oe and divider off");
      chk({7'd0, bit_clk}, 8'h01, "R12 bit clock high");
      sck_in = 0; int_bitclk = 1;
      #1;
      chk({7'd0, bit_clk}, 8'h00, "R12 bit clock low");

      // R11 internal without output
      wr(3'd2, 8'h00);
      #1;
      chk({6'd0, sck_oe, bit_clk}, 8'h01, "R11 no clock out");

      repeat (2) @(negedge clk);
      finish_run();
   end

endmodule